// File: doc/BRIEF.md
# Register Bus Address-Window Splitter

This block fans one upstream register bus out to several downstream register ports. Each downstream port owns an address window, defined by a base address and a log2 window size given as parameters. When the upstream master issues a read or write strobe, the block finds the matching window. It then sends a one-cycle strobe of the same kind to that port only, together with the window-relative address and the write data. The port's handshake reply is passed back upstream in the same form the master expects.

The reply can be data-ready with read data, no-more-data, write-acknowledge or unknown-address. Addresses that fall in no window are answered locally with unknown-address. The block keeps no timer of its own: an access the selected port never answers is closed by the upstream master's timeout.

The bus is strobe-driven and has no back-pressure. There is no valid/ready pair: each strobe is one access. A port signals that it cannot accept data through the no-more-data reply, not by stalling the strobe. A new upstream strobe always replaces any access still pending.

Top module: `split_bus`

## Requirements
- R1: Port i matches an address when the address bits at and above position LOG2[i] equal the same bits of BASE[i]. With the defaults, port 0 (base 0xA000, size 2^8) covers 0xA000–0xA0FF, port 1 (base 0x8000, size 2^6) covers 0x8000–0x803F, and port 2 (base 0x8000, size 2^12) covers 0x8000–0x8FFF.
- R2: An upstream strobe that matches a window makes the matched port's strobe (read for read, write for write) high for exactly one cycle, starting the cycle after the upstream strobe. No other port strobe is high. During that cycle `pt_addr` carries the address with the bits at and above LOG2 cleared, and `pt_wdata` carries the write data.
- R3: When windows overlap, the port with the lowest index takes the access. With the defaults, 0x8000–0x803F goes to port 1 and 0x8040–0x8FFF goes to port 2.
- R4: An access that matches no window strobes no port. It raises `up_unknown` for exactly one cycle, the cycle after the upstream strobe.
- R5: While an access is pending, the selected port's data-ready is passed upstream in the same cycle with its read data, but only for a read. The selected port's write-acknowledge is passed upstream only for a write.
- R6: The selected port's no-more-data and unknown-address replies are passed upstream in the same cycle, for reads and for writes alike.
- R7: Replies from unselected ports, and all replies when no access is pending, leave every upstream reply line low and `up_rdata` zero.
- R8: The first reply that is passed upstream ends the access. Later replies from the same port are ignored until the next strobe.
- R9: While reset (`rst_n` low, synchronous) is applied, and after it, all port strobes and upstream reply lines are low and no access is pending.
- R10: Data-ready during a write access and write-acknowledge during a read access are ignored and do not end the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_rd | input | 1 | Upstream read strobe |
| up_wr | input | 1 | Upstream write strobe |
| up_addr | input | ADDR_W | Upstream address, valid with a strobe |
| up_wdata | input | DATA_W | Upstream write data, valid with a write strobe |
| up_rdata | output | DATA_W | Read data, valid with up_ready, else zero |
| up_ready | output | 1 | Read data ready |
| up_nomore | output | 1 | Source empty (read) or port busy (write) |
| up_ack | output | 1 | Write accepted |
| up_unknown | output | 1 | Address not served |
| pt_rd | output | NUM_PORTS | Per-port read strobe |
| pt_wr | output | NUM_PORTS | Per-port write strobe |
| pt_addr | output | ADDR_W | Window-relative address, shared by all ports |
| pt_wdata | output | DATA_W | Write data, shared by all ports |
| pt_rdata | input | NUM_PORTS x DATA_W | Per-port read data |
| pt_ready | input | NUM_PORTS | Per-port data ready |
| pt_nomore | input | NUM_PORTS | Per-port no-more-data |
| pt_ack | input | NUM_PORTS | Per-port write acknowledge |
| pt_unknown | input | NUM_PORTS | Per-port unknown address |

## Verification
The bench aims at the window edges (0xA0FF against 0xA100, 0x803F against 0x8040, 0x8FFF against 0x9000). A decoder with an off-by-one mask would strobe the wrong port there, or none. It also aims at the overlap of ports 1 and 2: a priority encoder that favours the highest index would send 0x8000–0x803F to port 2. In the strobe cycle it drives replies from unselected ports, and wrong-kind replies from the selected port. A design that ORed all replies together, or did not filter by access kind, would leak these upstream or close the access early. Each real reply is repeated one cycle later, so a design that does not end the access on the first reply would pass the repeat through.

// File: rtl/split_pkg.sv
package split_pkg;
  // One port's handshake reply, bundled for internal routing.
  typedef struct packed {
    logic ready;
    logic nomore;
    logic ack;
    logic unknown;
  } reply_t;
endpackage

// File: rtl/split_decode.sv
module split_decode #(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned LOG2_W    = 8,
  parameter logic [NUM_PORTS-1:0][ADDR_W-1:0] PORT_BASE = '0,
  parameter logic [NUM_PORTS-1:0][LOG2_W-1:0] PORT_LOG2 = '0,
  localparam int unsigned IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] rel
);
  logic [NUM_PORTS-1:0]             hit_v;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] mask_v;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_win
    assign hit_v[i]  = (addr >> PORT_LOG2[i]) == (PORT_BASE[i] >> PORT_LOG2[i]);
    assign mask_v[i] = (ADDR_W'(1) << PORT_LOG2[i]) - ADDR_W'(1);
  end

  // Lowest index wins: scan downward so the last assignment is the lowest hit.
  always_comb begin
    hit = |hit_v;
    idx = '0;
    rel = '0;
    for (int i = NUM_PORTS - 1; i >= 0; i--) begin
      if (hit_v[i]) begin
        idx = IDX_W'(i);
        rel = addr & mask_v[i];
      end
    end
  end
endmodule

// File: rtl/split_reply.sv
module split_reply
  import split_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                             busy,
  input  logic                             is_rd,
  input  logic [IDX_W-1:0]                 sel,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] pt_rdata,
  input  logic [NUM_PORTS-1:0]             pt_ready,
  input  logic [NUM_PORTS-1:0]             pt_nomore,
  input  logic [NUM_PORTS-1:0]             pt_ack,
  input  logic [NUM_PORTS-1:0]             pt_unknown,
  output reply_t                           fwd,
  output logic [DATA_W-1:0]                fwd_rdata,
  output logic                             done
);
  logic live;
  assign live = busy && (32'(sel) < NUM_PORTS);

  always_comb begin
    fwd.ready   = live &&  is_rd && pt_ready[sel];
    fwd.ack     = live && !is_rd && pt_ack[sel];
    fwd.nomore  = live && pt_nomore[sel];
    fwd.unknown = live && pt_unknown[sel];
    fwd_rdata   = fwd.ready ? pt_rdata[sel] : '0;
    done        = |fwd;
  end
endmodule

// File: rtl/split_bus.sv
module split_bus
  import split_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LOG2_W    = 8,
  parameter logic [NUM_PORTS-1:0][ADDR_W-1:0] PORT_BASE = {16'h8000, 16'h8000, 16'hA000},
  parameter logic [NUM_PORTS-1:0][LOG2_W-1:0] PORT_LOG2 = {8'd12, 8'd6, 8'd8},
  localparam int unsigned IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             up_rd,
  input  logic                             up_wr,
  input  logic [ADDR_W-1:0]                up_addr,
  input  logic [DATA_W-1:0]                up_wdata,
  output logic [DATA_W-1:0]                up_rdata,
  output logic                             up_ready,
  output logic                             up_nomore,
  output logic                             up_ack,
  output logic                             up_unknown,
  output logic [NUM_PORTS-1:0]             pt_rd,
  output logic [NUM_PORTS-1:0]             pt_wr,
  output logic [ADDR_W-1:0]                pt_addr,
  output logic [DATA_W-1:0]                pt_wdata,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] pt_rdata,
  input  logic [NUM_PORTS-1:0]             pt_ready,
  input  logic [NUM_PORTS-1:0]             pt_nomore,
  input  logic [NUM_PORTS-1:0]             pt_ack,
  input  logic [NUM_PORTS-1:0]             pt_unknown
);
  logic              dec_hit;
  logic [IDX_W-1:0]  dec_idx;
  logic [ADDR_W-1:0] dec_rel;
  logic              strobe;

  logic [NUM_PORTS-1:0] rd_q, wr_q;
  logic [ADDR_W-1:0]    rel_q;
  logic [DATA_W-1:0]    wdata_q;
  logic                 busy_q, isrd_q, miss_q;
  logic [IDX_W-1:0]     sel_q;

  reply_t            fwd;
  logic [DATA_W-1:0] fwd_rdata;
  logic              done;

  assign strobe = up_rd | up_wr;

  split_decode #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .LOG2_W(LOG2_W),
    .PORT_BASE(PORT_BASE), .PORT_LOG2(PORT_LOG2)
  ) u_dec (
    .addr(up_addr), .hit(dec_hit), .idx(dec_idx), .rel(dec_rel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wr_q    <= '0;
      rel_q   <= '0;
      wdata_q <= '0;
      busy_q  <= 1'b0;
      isrd_q  <= 1'b0;
      miss_q  <= 1'b0;
      sel_q   <= '0;
    end else begin
      rd_q   <= '0;
      wr_q   <= '0;
      miss_q <= 1'b0;
      if (strobe) begin
        isrd_q <= up_rd;
        if (dec_hit) begin
          rd_q[dec_idx] <= up_rd;
          wr_q[dec_idx] <= ~up_rd;
          rel_q         <= dec_rel;
          wdata_q       <= up_wdata;
          sel_q         <= dec_idx;
          busy_q        <= 1'b1;
        end else begin
          miss_q <= 1'b1;
          busy_q <= 1'b0;
        end
      end else if (done) begin
        busy_q <= 1'b0;
      end
    end
  end

  split_reply #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_rep (
    .busy(busy_q), .is_rd(isrd_q), .sel(sel_q),
    .pt_rdata(pt_rdata), .pt_ready(pt_ready), .pt_nomore(pt_nomore),
    .pt_ack(pt_ack), .pt_unknown(pt_unknown),
    .fwd(fwd), .fwd_rdata(fwd_rdata), .done(done)
  );

  assign pt_rd      = rd_q;
  assign pt_wr      = wr_q;
  assign pt_addr    = rel_q;
  assign pt_wdata   = wdata_q;
  assign up_rdata   = fwd_rdata;
  assign up_ready   = fwd.ready;
  assign up_nomore  = fwd.nomore;
  assign up_ack     = fwd.ack;
  assign up_unknown = fwd.unknown | miss_q;
endmodule

// File: rtl/split_bus_chk.sv
module split_bus_chk #(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 up_rd,
  input logic                 up_wr,
  input logic [DATA_W-1:0]    up_rdata,
  input logic                 up_ready,
  input logic                 up_ack,
  input logic [NUM_PORTS-1:0] pt_rd,
  input logic [NUM_PORTS-1:0] pt_wr
);
  AST_ONE_PORT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pt_rd, pt_wr})); // R2
  AST_RD_FOLLOWS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (|pt_rd) |-> $past(up_rd)); // R2
  AST_WR_FOLLOWS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (|pt_wr) |-> $past(up_wr)); // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|{pt_rd, pt_wr}) |=> !(|{pt_rd, pt_wr}) || $past(up_rd | up_wr)); // R2
  AST_KIND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_ready && up_ack)); // R10
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !up_ready |-> (up_rdata == '0)); // R7
endmodule

bind split_bus split_bus_chk #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_rd(up_rd), .up_wr(up_wr),
  .up_rdata(up_rdata), .up_ready(up_ready), .up_ack(up_ack),
  .pt_rd(pt_rd), .pt_wr(pt_wr)
);

// File: tb/sim_split_bus.sv
`timescale 1ns/1ps
module sim_split_bus;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_rd = 0, up_wr = 0;
  logic [15:0] up_addr = '0;
  logic [31:0] up_wdata = '0;
  logic [31:0] up_rdata;
  logic up_ready, up_nomore, up_ack, up_unknown;
  logic [N-1:0] pt_rd, pt_wr;
  logic [15:0] pt_addr;
  logic [31:0] pt_wdata;
  logic [N-1:0][31:0] pt_rdata = '0;
  logic [N-1:0] pt_ready = '0, pt_nomore = '0, pt_ack = '0, pt_unknown = '0;

  int vecs = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  split_bus u0 (
    .clk(clk), .rst_n(rst_n), .up_rd(up_rd), .up_wr(up_wr),
    .up_addr(up_addr), .up_wdata(up_wdata), .up_rdata(up_rdata),
    .up_ready(up_ready), .up_nomore(up_nomore), .up_ack(up_ack),
    .up_unknown(up_unknown), .pt_rd(pt_rd), .pt_wr(pt_wr),
    .pt_addr(pt_addr), .pt_wdata(pt_wdata), .pt_rdata(pt_rdata),
    .pt_ready(pt_ready), .pt_nomore(pt_nomore), .pt_ack(pt_ack),
    .pt_unknown(pt_unknown)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected owner of an address under the window rule, lowest index first.
  function automatic int exp_port(input logic [15:0] a);
    if (a[15:8] == 8'hA0) return 0;
    if (a[15:6] == 10'h200) return 1;
    if (a[15:12] == 4'h8) return 2;
    return -1;
  endfunction

  function automatic logic [15:0] exp_rel(input int p, input logic [15:0] a);
    case (p)
      0: return a & 16'h00FF;
      1: return a & 16'h003F;
      default: return a & 16'h0FFF;
    endcase
  endfunction

  function automatic logic [35:0] up_view();
    return {up_ready, up_nomore, up_ack, up_unknown, up_rdata};
  endfunction

  task automatic clr_replies();
    pt_ready = '0; pt_nomore = '0; pt_ack = '0; pt_unknown = '0; pt_rdata = '0;
  endtask

  // kind: 0 normal (ready/ack), 1 no-more-data, 2 unknown-address
  task automatic set_reply(input int p, input bit rd, input int kind, input logic [31:0] rdat);
    case (kind)
      0: if (rd) begin pt_ready[p] = 1'b1; pt_rdata[p] = rdat; end else pt_ack[p] = 1'b1;
      1: pt_nomore[p] = 1'b1;
      default: pt_unknown[p] = 1'b1;
    endcase
  endtask

  task automatic access(input bit rd, input logic [15:0] a, input logic [31:0] d,
                        input int kind, input logic [31:0] rdat, input int dly);
    int p;
    logic [5:0] es;
    logic [35:0] eu;
    p = exp_port(a);
    @(negedge clk);
    up_rd = rd; up_wr = !rd; up_addr = a; up_wdata = d;
    @(negedge clk);
    up_rd = 0; up_wr = 0;
    if (p < 0) begin
      chk("R4 no port strobe", {58'd0, pt_rd, pt_wr}, 64'd0);
      chk("R4 unknown answered", {28'd0, up_view()}, {28'd0, 4'b0001, 32'd0});
      @(negedge clk);
      chk("R4 unknown one cycle", {63'd0, up_unknown}, 64'd0);
      return;
    end
    es = rd ? (6'b1 << (p + 3)) : (6'b1 << p);
    if (p == 1) chk("R3 overlap lowest index", {58'd0, pt_rd, pt_wr}, {58'd0, es});
    else        chk("R1 R2 window strobe", {58'd0, pt_rd, pt_wr}, {58'd0, es});
    chk("R2 relative address", {48'd0, pt_addr}, {48'd0, exp_rel(p, a)});
    if (!rd) chk("R2 write data", {32'd0, pt_wdata}, {32'd0, d});
    // Replies from an unselected port.
    set_reply((p + 1) % N, rd, 0, 32'hDEAD_BEEF);
    pt_nomore[(p + 1) % N] = 1'b1; pt_unknown[(p + 2) % N] = 1'b1;
    #1 chk("R7 unselected ignored", {28'd0, up_view()}, 64'd0);
    clr_replies();
    // Wrong-kind reply from the selected port.
    set_reply(p, !rd, 0, 32'hBAD0_0001);
    #1 chk("R10 wrong kind ignored", {28'd0, up_view()}, 64'd0);
    clr_replies();
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk("R2 strobe one cycle", {58'd0, pt_rd, pt_wr}, 64'd0);
    end
    set_reply(p, rd, kind, rdat);
    case (kind)
      0: eu = rd ? {4'b1000, rdat} : {4'b0010, 32'd0};
      1: eu = {4'b0100, 32'd0};
      default: eu = {4'b0001, 32'd0};
    endcase
    #1 begin
      if (kind == 0) chk("R5 reply forwarded", {28'd0, up_view()}, {28'd0, eu});
      else           chk("R6 reply forwarded", {28'd0, up_view()}, {28'd0, eu});
    end
    @(negedge clk);
    if (dly == 0) chk("R2 strobe one cycle", {58'd0, pt_rd, pt_wr}, 64'd0);
    #1 chk("R8 ended after reply", {28'd0, up_view()}, 64'd0);
    clr_replies();
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] edges [7];
    void'($urandom(32'd2024));
    edges = '{16'hA0FF, 16'hA100, 16'h9FFF, 16'h803F, 16'h8040, 16'h8FFF, 16'h9000};
    repeat (3) @(negedge clk);
    chk("R9 reset strobes low", {58'd0, pt_rd, pt_wr}, 64'd0);
    chk("R9 reset replies low", {28'd0, up_view()}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    pt_ready = '1; pt_ack = '1; pt_nomore = '1; pt_unknown = '1; pt_rdata = '1;
    #1 chk("R9 idle after reset", {28'd0, up_view()}, 64'd0);
    #1 chk("R7 idle replies ignored", {28'd0, up_view()}, 64'd0);
    clr_replies();
    // Directed window boundaries.
    access(1, 16'hA000, 32'h0, 0, 32'h1111_2222, 0);
    access(0, 16'hA0FF, 32'h3333_4444, 0, 32'h0, 0);
    access(1, 16'h8000, 32'h0, 1, 32'h0, 1);
    access(0, 16'h803F, 32'h5555_6666, 2, 32'h0, 2);
    foreach (edges[i]) access(i % 2 == 0, edges[i], $urandom, i % 3, $urandom, 0);
    access(0, 16'h0042, 32'h7, 0, 32'h0, 0);
    // Random mix.
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      case ($urandom % 5)
        0: a = {8'hA0, 8'($urandom)};
        1: a = 16'h8000 | 16'($urandom % 64);
        2: a = {4'h8, 12'($urandom)};
        3: a = edges[$urandom % 7];
        default: a = 16'($urandom);
      endcase
      access(1'($urandom), a, $urandom, int'($urandom % 3), $urandom, int'($urandom % 3));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule